// File: doc/BRIEF.md
# Contact Image Sensor Line-Scan Sequencer

This block runs a cascaded line-array image sensor from the system clock. It divides the system clock into a 50%-duty sensor pixel clock and issues a one-pixel-clock line start pulse at a programmed line period. It drives a resolution-select pin, and it counts the per-line preamble of dummy pixels and then the active pixels of the selected resolution. A sample strobe with a zero-based pixel index goes to an external ADC once per active pixel, a programmed number of system clocks after the pixel clock rises. The block also gates three LED enables so that the illumination can be off, white, or rotate red, green and blue one line at a time. A colour tag reports which colour lights the current line.

Settings are written through a plain register-style port (`cfg_we` plus fields). Each field is clamped into its legal range when it is written, and the block adopts it at the next line start, so one line never mixes two settings. The sample strobe is a valid-only stream. The sensor cannot pause mid-line, so there is no ready input, and the consumer must accept one index per strobe. Strobes are at least one pixel clock apart.

Top module: `cis_line_seq`

## Requirements
- R1: `sensor_clk` has equal high and low phases of H system clocks each, where H is `cfg_half` clamped into [MIN_HALF, MAX_HALF].
- R2: `line_start` rises and falls only in the cycle where `sensor_clk` falls, and it stays high for exactly one pixel clock period (2H system clocks). The single pixel clock rising edge it spans is pixel clock 1 of the line.
- R3: The period between successive `line_start` pixel clock edges is L pixel clocks. L is `cfg_line` clamped into [A + MARGIN, MAX_LINE], where A = CHIPS x PIX_HI when `cfg_hires` = 1 and A = CHIPS x PIX_LO otherwise.
- R4: `smp_stb` pulses for one cycle exactly once for each pixel clock DUMMY+1 .. DUMMY+A of a line. It never pulses for the dummy preamble or for the trailing clocks.
- R5: Each strobe comes D system clocks after the cycle in which `sensor_clk` went high, where D = min(`cfg_dly`, 2H-1). It therefore always precedes the next pixel clock rise.
- R6: `pix_idx` is valid while `smp_stb` is high. It counts 0, 1, .. A-1 across a line, that is, pixel clock number minus DUMMY minus 1.
- R7: `res_sel` equals the `cfg_hires` in force for the line. It changes only together with the rise of `line_start`.
- R8: Mode `cfg_mode` = 0 keeps all LEDs off. Mode 1 lights all three during a line. Modes 2 and 3 light exactly one LED, chosen by `col_tag` (0 = red, 1 = green, 2 = blue). The tag advances 0, 1, 2, 0 at each line start, and the first line after reset is tagged 0.
- R9: `line_busy` is high from pixel clock 1 through pixel clock DUMMY+A of a line and low for the rest of the line.
- R10: After reset, `line_start`, `smp_stb`, `line_busy` and all LEDs are low. Settings written with `cfg_we` take effect at the next line start. `cfg_run` = 0 lets the current line finish and then starts no further line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for all settings fields |
| cfg_run | input | 1 | 1 = keep scanning lines |
| cfg_hires | input | 1 | 1 = high resolution, 0 = low resolution |
| cfg_mode | input | 2 | LED mode: 0 off, 1 all, 2/3 rotate |
| cfg_half | input | HALF_W | Pixel clock half period in system clocks |
| cfg_line | input | LINE_W | Line period in pixel clocks |
| cfg_dly | input | HALF_W+1 | Strobe delay after pixel clock rise, system clocks |
| sensor_clk | output | 1 | Pixel clock to the sensor |
| line_start | output | 1 | Line start pulse to the sensor |
| res_sel | output | 1 | Resolution select to the sensor |
| led_r | output | 1 | Red LED enable |
| led_g | output | 1 | Green LED enable |
| led_b | output | 1 | Blue LED enable |
| smp_stb | output | 1 | ADC sample strobe (stream valid) |
| pix_idx | output | LINE_W | Active pixel index qualified by smp_stb |
| line_busy | output | 1 | Pixel readout of the line in progress |
| col_tag | output | 2 | Colour of the current line |

## Verification
The assertions assume consistent parameters: MIN_HALF of at least 1, MARGIN larger than DUMMY, and MAX_LINE no smaller than the low-resolution minimum and narrower than LINE_W. Under these assumptions a clamped setting can never produce a strobe window that overruns the line or a pixel clock phase shorter than MIN_HALF. Settings may arrive at any cycle. The bench therefore writes a setting, lets one line go by so that a line started before the write cannot be measured, and only then measures a full line. It runs with reduced chip and pixel counts so that whole lines fit in a short run. Its raw requested values include ones below and above every clamp.

// File: rtl/cis_seq_pkg.sv
package cis_seq_pkg;
  typedef enum logic [1:0] {COL_R = 2'd0, COL_G = 2'd1, COL_B = 2'd2} colour_e;
  typedef enum logic [1:0] {LED_OFF = 2'd0, LED_ALL = 2'd1, LED_ROT = 2'd2, LED_ROT3 = 2'd3} ledmode_e;

  function automatic colour_e col_next(colour_e c);
    case (c)
      COL_R:   col_next = COL_G;
      COL_G:   col_next = COL_B;
      default: col_next = COL_R;
    endcase
  endfunction
endpackage

// File: rtl/cis_cfg_reg.sv
module cis_cfg_reg #(
  parameter int HALF_W   = 8,
  parameter int LINE_W   = 16,
  parameter int MIN_HALF = 7,
  parameter int MAX_HALF = 50,
  parameter int MAX_LINE = 40000,
  parameter int MIN_HI   = 5310,
  parameter int MIN_LO   = 2730
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_run,
  input  logic              cfg_hires,
  input  logic [1:0]        cfg_mode,
  input  logic [HALF_W-1:0] cfg_half,
  input  logic [LINE_W-1:0] cfg_line,
  input  logic [HALF_W:0]   cfg_dly,
  output logic              run_q,
  output logic              hires_q,
  output cis_seq_pkg::ledmode_e mode_q,
  output logic [HALF_W-1:0] half_q,
  output logic [LINE_W-1:0] line_q,
  output logic [HALF_W:0]   dly_q
);
  import cis_seq_pkg::*;
  logic [HALF_W-1:0] half_c;
  logic [LINE_W-1:0] floor_c, line_c;
  logic [HALF_W:0]   dmax_c, dly_c;

  always_comb begin
    if (cfg_half < HALF_W'(MIN_HALF))      half_c = HALF_W'(MIN_HALF);
    else if (cfg_half > HALF_W'(MAX_HALF)) half_c = HALF_W'(MAX_HALF);
    else                                   half_c = cfg_half;
    floor_c = cfg_hires ? LINE_W'(MIN_HI) : LINE_W'(MIN_LO);
    if (cfg_line < floor_c)                line_c = floor_c;
    else if (cfg_line > LINE_W'(MAX_LINE)) line_c = LINE_W'(MAX_LINE);
    else                                   line_c = cfg_line;
    dmax_c = {half_c, 1'b0} - 1'b1;
    dly_c  = (cfg_dly > dmax_c) ? dmax_c : cfg_dly;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      hires_q <= 1'b1;
      mode_q  <= LED_OFF;
      half_q  <= HALF_W'(MIN_HALF);
      line_q  <= LINE_W'(MIN_HI);
      dly_q   <= '0;
    end else if (cfg_we) begin
      run_q   <= cfg_run;
      hires_q <= cfg_hires;
      mode_q  <= ledmode_e'(cfg_mode);
      half_q  <= half_c;
      line_q  <= line_c;
      dly_q   <= dly_c;
    end
  end

  // R1
  half_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_q >= HALF_W'(MIN_HALF)) && (half_q <= HALF_W'(MAX_HALF)));
  // R3
  line_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_q >= (hires_q ? LINE_W'(MIN_HI) : LINE_W'(MIN_LO)));
endmodule

// File: rtl/cis_pclk_gen.sv
module cis_pclk_gen #(
  parameter int HALF_W   = 8,
  parameter int MIN_HALF = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] half_use,
  output logic              cp,
  output logic              rise_ev,
  output logic              fall_ev
);
  logic [HALF_W-1:0] hcnt;
  logic              term;

  assign term    = (hcnt >= half_use - 1'b1);
  assign rise_ev = term && !cp;
  assign fall_ev = term && cp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      cp   <= 1'b0;
    end else if (term) begin
      hcnt <= '0;
      cp   <= ~cp;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  // checker state: cycles the clock level has been held
  logic [HALF_W-1:0] held;
  always_ff @(posedge clk) begin
    if (!rst_n)                   held <= HALF_W'(1);
    else if (term)                held <= HALF_W'(1);
    else if (held != '1)          held <= held + 1'b1;
  end

  // R1
  cp_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(cp) |-> ($past(held) >= HALF_W'(MIN_HALF)));
endmodule

// File: rtl/cis_line_ctl.sv
module cis_line_ctl #(
  parameter int HALF_W = 8,
  parameter int LINE_W = 16,
  parameter int DUMMY  = 82,
  parameter int ACT_HI = 5160,
  parameter int ACT_LO = 2580
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_q,
  input  logic              hires_q,
  input  cis_seq_pkg::ledmode_e mode_q,
  input  logic [HALF_W-1:0] half_q,
  input  logic [LINE_W-1:0] line_q,
  input  logic [HALF_W:0]   dly_q,
  input  logic              cp,
  input  logic              rise_ev,
  input  logic              fall_ev,
  output logic              sp,
  output logic              res_sel,
  output logic [HALF_W-1:0] half_use,
  output logic [HALF_W:0]   dly_sh,
  output logic              arm,
  output logic [LINE_W-1:0] arm_idx,
  output logic              busy,
  output logic [1:0]        col_tag,
  output logic              led_r,
  output logic              led_g,
  output logic              led_b
);
  import cis_seq_pkg::*;
  logic              active;
  logic [LINE_W-1:0] pos, line_sh, last_pix, next_pos;
  logic [HALF_W-1:0] half_sh;
  ledmode_e          mode_sh;
  colour_e           col_cur, col_nxt;
  logic              start_due;

  assign last_pix  = LINE_W'(DUMMY) + (res_sel ? LINE_W'(ACT_HI) : LINE_W'(ACT_LO));
  assign start_due = run_q && !sp && (!active || pos >= line_sh);
  assign next_pos  = sp ? LINE_W'(1) : pos + 1'b1;
  assign arm       = rise_ev && active && (next_pos > LINE_W'(DUMMY)) && (next_pos <= last_pix);
  assign arm_idx   = next_pos - LINE_W'(DUMMY + 1);
  assign busy      = active && (pos != '0) && (pos <= last_pix);
  assign half_use  = active ? half_sh : half_q;
  assign col_tag   = col_cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= 1'b0; active <= 1'b0; pos <= '0; line_sh <= '0;
      half_sh <= '0; dly_sh <= '0; res_sel <= 1'b0; mode_sh <= LED_OFF;
      col_cur <= COL_R; col_nxt <= COL_R;
    end else begin
      if (fall_ev) begin
        if (sp) begin
          sp <= 1'b0;
        end else if (start_due) begin
          sp      <= 1'b1;
          active  <= 1'b1;
          pos     <= '0;
          line_sh <= line_q;
          half_sh <= half_q;
          dly_sh  <= dly_q;
          res_sel <= hires_q;
          mode_sh <= mode_q;
          col_cur <= col_nxt;
          col_nxt <= col_next(col_nxt);
        end else if (active && pos >= line_sh) begin
          active <= 1'b0;
          pos    <= '0;
        end
      end
      if (rise_ev && active) pos <= next_pos;
    end
  end

  always_comb begin
    {led_r, led_g, led_b} = 3'b000;
    if (active) begin
      case (mode_sh)
        LED_ALL: {led_r, led_g, led_b} = 3'b111;
        LED_ROT, LED_ROT3: begin
          led_r = (col_cur == COL_R);
          led_g = (col_cur == COL_G);
          led_b = (col_cur == COL_B);
        end
        default: {led_r, led_g, led_b} = 3'b000;
      endcase
    end
  end

  // R2
  sp_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sp) |-> $fell(cp));
  // R7
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(res_sel) |-> $rose(sp));
  // R8
  led_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sh[1] |-> $onehot0({led_r, led_g, led_b}));
  // R9
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> sp);
endmodule

// File: rtl/cis_strobe_dly.sv
module cis_strobe_dly #(
  parameter int HALF_W = 8,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [LINE_W-1:0] arm_idx,
  input  logic [HALF_W:0]   dly_sh,
  output logic              stb,
  output logic [LINE_W-1:0] idx
);
  logic            pend;
  logic [HALF_W:0] cnt;

  assign stb = pend && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; cnt <= '0; idx <= '0;
    end else if (arm) begin
      pend <= 1'b1; cnt <= dly_sh; idx <= arm_idx;
    end else if (pend) begin
      if (cnt == '0) pend <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // R5
  stb_before_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && pend) |-> (cnt == '0));
endmodule

// File: rtl/cis_line_seq.sv
module cis_line_seq #(
  parameter int CHIPS    = 15,
  parameter int PIX_HI   = 344,
  parameter int PIX_LO   = 172,
  parameter int DUMMY    = 82,
  parameter int MARGIN   = 150,
  parameter int MIN_HALF = 7,
  parameter int MAX_HALF = 50,
  parameter int MAX_LINE = 40000,
  parameter int HALF_W   = 8,
  parameter int LINE_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_run,
  input  logic              cfg_hires,
  input  logic [1:0]        cfg_mode,
  input  logic [HALF_W-1:0] cfg_half,
  input  logic [LINE_W-1:0] cfg_line,
  input  logic [HALF_W:0]   cfg_dly,
  output logic              sensor_clk,
  output logic              line_start,
  output logic              res_sel,
  output logic              led_r,
  output logic              led_g,
  output logic              led_b,
  output logic              smp_stb,
  output logic [LINE_W-1:0] pix_idx,
  output logic              line_busy,
  output logic [1:0]        col_tag
);
  import cis_seq_pkg::*;
  localparam int ACT_HI = CHIPS * PIX_HI;
  localparam int ACT_LO = CHIPS * PIX_LO;

  logic              run_q, hires_q, rise_ev, fall_ev, arm;
  ledmode_e          mode_q;
  logic [HALF_W-1:0] half_q, half_use;
  logic [LINE_W-1:0] line_q, arm_idx;
  logic [HALF_W:0]   dly_q, dly_sh;

  cis_cfg_reg #(.HALF_W(HALF_W), .LINE_W(LINE_W), .MIN_HALF(MIN_HALF), .MAX_HALF(MAX_HALF),
                .MAX_LINE(MAX_LINE), .MIN_HI(ACT_HI + MARGIN), .MIN_LO(ACT_LO + MARGIN)) u_cfg (
    .clk, .rst_n, .cfg_we, .cfg_run, .cfg_hires, .cfg_mode, .cfg_half, .cfg_line, .cfg_dly,
    .run_q, .hires_q, .mode_q, .half_q, .line_q, .dly_q);

  cis_pclk_gen #(.HALF_W(HALF_W), .MIN_HALF(MIN_HALF)) u_pclk (
    .clk, .rst_n, .half_use, .cp(sensor_clk), .rise_ev, .fall_ev);

  cis_line_ctl #(.HALF_W(HALF_W), .LINE_W(LINE_W), .DUMMY(DUMMY),
                 .ACT_HI(ACT_HI), .ACT_LO(ACT_LO)) u_ctl (
    .clk, .rst_n, .run_q, .hires_q, .mode_q, .half_q, .line_q, .dly_q,
    .cp(sensor_clk), .rise_ev, .fall_ev, .sp(line_start), .res_sel, .half_use, .dly_sh,
    .arm, .arm_idx, .busy(line_busy), .col_tag, .led_r, .led_g, .led_b);

  cis_strobe_dly #(.HALF_W(HALF_W), .LINE_W(LINE_W)) u_stb (
    .clk, .rst_n, .arm, .arm_idx, .dly_sh, .stb(smp_stb), .idx(pix_idx));

  // R4
  stb_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> line_busy);
endmodule

// File: tb/cis_line_seq_tb_top.sv
module cis_line_seq_tb_top;
  localparam int HW = 8;
  localparam int LW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_run = 0, cfg_hires = 0;
  logic [1:0] cfg_mode = 0;
  logic [HW-1:0] cfg_half = 0;
  logic [LW-1:0] cfg_line = 0;
  logic [HW:0] cfg_dly = 0;
  logic cp, sp, res_sel, led_r, led_g, led_b, stb, busy;
  logic [LW-1:0] pix_idx;
  logic [1:0] col_tag;

  always #10 clk = ~clk;

  cis_line_seq #(.CHIPS(2), .PIX_HI(6), .PIX_LO(3), .DUMMY(4), .MARGIN(5), .MIN_HALF(2),
                 .MAX_HALF(6), .MAX_LINE(60), .HALF_W(HW), .LINE_W(LW)) dut_i (
    .clk, .rst_n, .cfg_we, .cfg_run, .cfg_hires, .cfg_mode, .cfg_half, .cfg_line, .cfg_dly,
    .sensor_clk(cp), .line_start(sp), .res_sel, .led_r, .led_g, .led_b,
    .smp_stb(stb), .pix_idx, .line_busy(busy), .col_tag);

  typedef struct packed {
    logic hires; logic [7:0] half; logic [15:0] line; logic [8:0] dly;
    logic [15:0] e_line; logic [7:0] e_half; logic [15:0] e_stb; logic [8:0] e_dly;
  } vec_t;
  // active: hires 12, lores 6; line floor 17 / 11; half in [2,6]; delay <= 2H-1
  localparam vec_t VECS [6] = '{
    '{1'b1, 8'd2, 16'd20,  9'd1,  16'd20, 8'd2, 16'd12, 9'd1},
    '{1'b0, 8'd3, 16'd15,  9'd4,  16'd15, 8'd3, 16'd6,  9'd4},
    '{1'b1, 8'd4, 16'd5,   9'd2,  16'd17, 8'd4, 16'd12, 9'd2},
    '{1'b0, 8'd1, 16'd30,  9'd0,  16'd30, 8'd2, 16'd6,  9'd0},
    '{1'b1, 8'd9, 16'd100, 9'd15, 16'd60, 8'd6, 16'd12, 9'd11},
    '{1'b0, 8'd5, 16'd10,  9'd20, 16'd11, 8'd5, 16'd6,  9'd9}
  };

  int n_chk = 0, n_bad = 0;
  int lines_seen = 0, rise_no = 0, stb_cnt = 0, first_pos = 0, dly_meas = 0, since_rise = 0;
  int idx_bad = 0, lvl_len = 0, hi_meas = 0, lo_meas = 0, sp_len = 0, sp_meas = 0;
  int ln_len = 0, ln_stb = 0, ln_first = 0, ln_dly = 0, ln_idx_bad = 0;
  logic cp_d = 0, sp_d = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      rise_no = 0; stb_cnt = 0; lvl_len = 0; sp_len = 0; cp_d = 0; sp_d = 0;
    end else begin
      if (cp && !cp_d) begin
        if (sp) begin
          ln_len = rise_no; ln_stb = stb_cnt; ln_first = first_pos;
          ln_dly = dly_meas; ln_idx_bad = idx_bad;
          lines_seen++; rise_no = 1; stb_cnt = 0; first_pos = 0; idx_bad = 0;
        end else rise_no++;
        since_rise = 0;
      end else since_rise++;
      if (cp != cp_d) begin
        if (cp_d) hi_meas = lvl_len; else lo_meas = lvl_len;
        lvl_len = 1;
      end else lvl_len++;
      if (sp) sp_len++;
      else if (sp_d) begin sp_meas = sp_len; sp_len = 0; end
      if (stb) begin
        if (stb_cnt == 0) begin first_pos = rise_no; dly_meas = since_rise; end
        if (int'(pix_idx) != stb_cnt) idx_bad++;
        stb_cnt++;
      end
      cp_d = cp; sp_d = sp;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic write_cfg(logic run, logic hi, logic [1:0] md, int half, int line, int dly);
    cfg_run = run; cfg_hires = hi; cfg_mode = md;
    cfg_half = HW'(half); cfg_line = LW'(line); cfg_dly = (HW+1)'(dly);
    cfg_we = 1'b1;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic wait_lines(int n);
    int target;
    target = lines_seen + n;
    while (lines_seen < target) tick(1);
  endtask

  task automatic wait_rise(int r);
    while (rise_no != r) tick(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int prev;
    tick(5);
    // R10 reset state
    chk("R10 reset line_start", sp, 0);
    chk("R10 reset strobe", stb, 0);
    chk("R10 reset busy", busy, 0);
    chk("R10 reset leds", {led_r, led_g, led_b}, 0);
    rst_n = 1'b1;
    tick(20);
    chk("R10 idle before run", sp, 0);

    // R8 first line after reset is red
    write_cfg(1, 1, 2, 2, 20, 1);
    wait_lines(1);
    chk("R8 first tag", col_tag, 0);
    chk("R8 first led", {led_r, led_g, led_b}, 3'b100);

    foreach (VECS[i]) begin
      write_cfg(1, VECS[i].hires, 2, VECS[i].half, VECS[i].line, VECS[i].dly);
      wait_lines(3);
      chk("R3 line period", ln_len, int'(VECS[i].e_line));
      chk("R1 high phase", hi_meas, int'(VECS[i].e_half));
      chk("R1 low phase", lo_meas, int'(VECS[i].e_half));
      chk("R2 start width", sp_meas, 2 * int'(VECS[i].e_half));
      chk("R4 strobe count", ln_stb, int'(VECS[i].e_stb));
      chk("R4 first strobe clock", ln_first, 5);
      chk("R5 strobe delay", ln_dly, int'(VECS[i].e_dly));
      chk("R6 index sequence errors", ln_idx_bad, 0);
      chk("R7 res_sel", res_sel, int'(VECS[i].hires));
    end

    // R8 rotation order and LED selection
    write_cfg(1, 0, 2, 2, 12, 0);
    wait_lines(2);
    prev = col_tag;
    for (int k = 0; k < 3; k++) begin
      wait_lines(1);
      chk("R8 colour order", col_tag, (prev + 1) % 3);
      chk("R8 rotate led", {led_r, led_g, led_b}, 3'b100 >> col_tag);
      prev = col_tag;
    end

    // R8 white and off modes
    write_cfg(1, 0, 1, 2, 12, 0);
    wait_lines(2);
    chk("R8 white mode", {led_r, led_g, led_b}, 3'b111);
    write_cfg(1, 0, 0, 2, 12, 0);
    wait_lines(2);
    chk("R8 off mode", {led_r, led_g, led_b}, 3'b000);

    // R9 busy window: lores readout ends at clock 10 of a 30-clock line
    write_cfg(1, 0, 2, 2, 30, 0);
    wait_lines(2);
    wait_rise(3);
    chk("R9 busy during readout", busy, 1);
    wait_rise(10);
    chk("R9 busy at last pixel", busy, 1);
    wait_rise(11);
    chk("R9 busy after readout", busy, 0);
    chk("R4 no strobe after readout", stb_cnt, 6);
    chk("R7 res_sel low res", res_sel, 0);

    // R10 stop: current line ends, no further line
    write_cfg(0, 0, 2, 2, 30, 0);
    tick(300);
    prev = lines_seen;
    tick(300);
    chk("R10 no line after stop", lines_seen, prev);
    chk("R10 stopped busy", busy, 0);
    chk("R10 stopped leds", {led_r, led_g, led_b}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule